// File: doc/BRIEF.md
# Lockable Per-Core Debug Enable Register Block

This block is an APB slave that decodes a 4 KB register window and holds one debug control register for each of a small set of processor cores and accelerators. A single bit of each register drives that core's debug-enable output. Ordinary software can always read these registers. It can write them only after it has opened a software lock by writing a fixed 32-bit key to a lock-access register. A lock-status register reports whether the lock is shut or open.

An external debugger marks its accesses with a sideband flag, which stands in for a high address bit. Such accesses write the control registers whatever the lock state. The first control register also reports the low-power state of its core on one read-only bit, taken from an input pin. Every transfer completes in its access phase with no wait states and no error response.

Top module: `dbgctl_top`

## Requirements
- R1: After reset the lock is shut, so the lock-status register at offset 0xFB4 reads 3. All control registers read zero and every `dbg_en_o` bit is low.
- R2: An APB write of 0xC5ACCE55 to offset 0xFB0 opens the lock, and from the next cycle the lock-status register reads 1.
- R3: An APB write of any other value to offset 0xFB0 shuts the lock again, and the lock-status register then reads 3.
- R4: While the lock is shut, a write to a control register with `pdbg_i` low is ignored. The register's readback and its `dbg_en_o` bit keep their old values.
- R5: A write with `pdbg_i` high updates a control register even while the lock is shut.
- R6: Bit 13 of control register i drives `dbg_en_o[i]`. The output takes the written bit at the clock edge that completes the accepted write.
- R7: Bit 21 of control register 0 always reads the current level of `core_lp_i`. Writing that bit has no effect. On the other registers bit 21 is an ordinary read/write bit.
- R8: Control registers can be read whatever the lock state.
- R9: Reads of offset 0xFB0 and of any offset that is not decoded return zero.
- R10: `pready` is always high and `pslverr` is always low.
- R11: Control register i sits at byte offset 0x030 + 4*i, for i = 0 to 4. A write to one register leaves the other registers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | APB clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset within the 4 KB window |
| pwdata | input | 32 | Write data |
| pdbg_i | input | 1 | Access comes from the external debugger and bypasses the lock |
| core_lp_i | input | 1 | Low-power status of core 0 |
| prdata | output | 32 | Read data |
| pready | output | 1 | Transfer ready (always high) |
| pslverr | output | 1 | Transfer error (always low) |
| dbg_en_o | output | 5 | Debug enable, one bit per core |

## Verification
A wrong lock state shows up at once in the lock-status readback, which returns 3 where 1 is expected or the reverse. It also shows up as an ignored or wrongly accepted control write, which is visible in `dbg_en_o` one edge after the write and in the next readback of that register. A decode fault makes a write land in a neighbouring register, so the bench reads back every register after each group of writes. A fault in the bypass path shows only when a debugger write is made while the lock is shut, so the bench makes such writes on purpose.

// File: rtl/dbgctl_pkg.sv
package dbgctl_pkg;

   // key that opens the software lock
   localparam logic [31:0] LOCK_KEY = 32'hC5AC_CE55;

   // encoding returned by the lock-status register
   typedef enum logic [1:0] {
      LK_OPEN = 2'd1,
      LK_SHUT = 2'd3
   } lock_stat_e;

endpackage

// File: rtl/dbgctl_decode.sv
module dbgctl_decode #(
   parameter int ADDR_W    = 12,
   parameter int NUM_CORES = 5,
   parameter int CTL_BASE  = 'h030,
   parameter int CTL_STEP  = 4,
   parameter int LOCK_OFF  = 'hFB0,
   parameter int STAT_OFF  = 'hFB4
) (
   input  logic [ADDR_W-1:0]    addr,
   output logic [NUM_CORES-1:0] ctl_hit,
   output logic                 lock_hit,
   output logic                 stat_hit
);

   localparam int LAST_CTL = CTL_BASE + CTL_STEP * (NUM_CORES - 1);

   if (LAST_CTL >= LOCK_OFF) begin : g_bad_map
      $error("control registers overlap the lock registers");
   end

   for (genvar gi = 0; gi < NUM_CORES; gi++) begin : g_hit
      localparam int OFF = CTL_BASE + CTL_STEP * gi;
      assign ctl_hit[gi] = (addr == ADDR_W'(OFF));
   end

   assign lock_hit = (addr == ADDR_W'(LOCK_OFF));
   assign stat_hit = (addr == ADDR_W'(STAT_OFF));

endmodule

// File: rtl/dbgctl_lock.sv
module dbgctl_lock
   import dbgctl_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_lock,
   input  logic [DATA_W-1:0] wdata,
   output logic              locked,
   output lock_stat_e        status
);

   if (DATA_W != 32) begin : g_bad_w
      $error("lock key needs a 32-bit data path");
   end

   logic key_ok;
   assign key_ok = (wdata == LOCK_KEY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked <= 1'b1;
      end else if (wr_lock) begin
         locked <= !key_ok;
      end
   end

   assign status = locked ? LK_SHUT : LK_OPEN;

   AST_KEY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lock && wdata == 32'hC5AC_CE55) |=> (status == LK_OPEN)); // R2

   AST_BADKEY_SHUTS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lock && wdata != 32'hC5AC_CE55) |=> (status == LK_SHUT)); // R3

   AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_lock |=> $stable(locked)); // R3

endmodule

// File: rtl/dbgctl_core_reg.sv
module dbgctl_core_reg #(
   parameter int DATA_W  = 32,
   parameter int DBG_BIT = 13,
   parameter int LP_BIT  = 21,
   parameter bit HAS_LP  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   input  logic              lp_in,
   output logic [DATA_W-1:0] rd_val,
   output logic              dbg_en
);

   if (DBG_BIT >= DATA_W || LP_BIT >= DATA_W || DBG_BIT == LP_BIT) begin : g_bad_bits
      $error("bad control bit positions");
   end

   localparam logic [DATA_W-1:0] LP_MASK  = DATA_W'(1) << LP_BIT;
   localparam logic [DATA_W-1:0] WR_MASK  = HAS_LP ? ~LP_MASK : '1;

   logic [DATA_W-1:0] q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (wr_en) begin
         q <= wdata & WR_MASK;
      end
   end

   if (HAS_LP) begin : g_lp
      assign rd_val = (q & ~LP_MASK) | (lp_in ? LP_MASK : '0);
   end else begin : g_plain
      logic lp_unused;
      assign lp_unused = lp_in;
      assign rd_val    = q;
   end

   assign dbg_en = q[DBG_BIT];

   AST_EN_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (dbg_en == $past(wdata[DBG_BIT]))); // R6

   AST_EN_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(dbg_en)); // R4

endmodule

// File: rtl/dbgctl_rdmux.sv
module dbgctl_rdmux
   import dbgctl_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int NUM_CORES = 5
) (
   input  logic [NUM_CORES-1:0]             ctl_hit,
   input  logic                             stat_hit,
   input  logic [NUM_CORES-1:0][DATA_W-1:0] ctl_val,
   input  lock_stat_e                       status,
   output logic [DATA_W-1:0]                rdata
);

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_CORES; i++) begin
         if (ctl_hit[i]) rdata = rdata | ctl_val[i];
      end
      if (stat_hit) rdata = rdata | DATA_W'(status);
   end

endmodule

// File: rtl/dbgctl_top.sv
module dbgctl_top
   import dbgctl_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int DATA_W    = 32,
   parameter int NUM_CORES = 5,
   parameter int DBG_BIT   = 13,
   parameter int LP_BIT    = 21
) (
   input  logic                 pclk,
   input  logic                 presetn,
   input  logic                 psel,
   input  logic                 penable,
   input  logic                 pwrite,
   input  logic [ADDR_W-1:0]    paddr,
   input  logic [DATA_W-1:0]    pwdata,
   input  logic                 pdbg_i,
   input  logic                 core_lp_i,
   output logic [DATA_W-1:0]    prdata,
   output logic                 pready,
   output logic                 pslverr,
   output logic [NUM_CORES-1:0] dbg_en_o
);

   if (ADDR_W < 12) begin : g_bad_addr
      $error("window needs at least 12 address bits");
   end
   if (NUM_CORES < 1 || NUM_CORES > 32) begin : g_bad_n
      $error("NUM_CORES out of range");
   end

   logic [NUM_CORES-1:0]             ctl_hit;
   logic                             lock_hit;
   logic                             stat_hit;
   logic                             acc_wr;
   logic                             locked;
   lock_stat_e                       status;
   logic [NUM_CORES-1:0][DATA_W-1:0] ctl_val;
   logic                             ctl_wr_ok;

   assign acc_wr    = psel && penable && pwrite;
   assign ctl_wr_ok = acc_wr && (pdbg_i || !locked);

   dbgctl_decode #(
      .ADDR_W    (ADDR_W),
      .NUM_CORES (NUM_CORES)
   ) i_decode (
      .addr     (paddr),
      .ctl_hit  (ctl_hit),
      .lock_hit (lock_hit),
      .stat_hit (stat_hit)
   );

   dbgctl_lock #(
      .DATA_W (DATA_W)
   ) i_lock (
      .clk     (pclk),
      .rst_n   (presetn),
      .wr_lock (acc_wr && lock_hit),
      .wdata   (pwdata),
      .locked  (locked),
      .status  (status)
   );

   for (genvar gc = 0; gc < NUM_CORES; gc++) begin : g_core
      dbgctl_core_reg #(
         .DATA_W  (DATA_W),
         .DBG_BIT (DBG_BIT),
         .LP_BIT  (LP_BIT),
         .HAS_LP  (gc == 0)
      ) i_reg (
         .clk    (pclk),
         .rst_n  (presetn),
         .wr_en  (ctl_wr_ok && ctl_hit[gc]),
         .wdata  (pwdata),
         .lp_in  (core_lp_i),
         .rd_val (ctl_val[gc]),
         .dbg_en (dbg_en_o[gc])
      );

      AST_DBG_BYPASS: assert property (@(posedge pclk) disable iff (!presetn)
         (acc_wr && pdbg_i && ctl_hit[gc]) |=> (dbg_en_o[gc] == $past(pwdata[DBG_BIT]))); // R5
   end

   dbgctl_rdmux #(
      .DATA_W    (DATA_W),
      .NUM_CORES (NUM_CORES)
   ) i_rdmux (
      .ctl_hit  (ctl_hit),
      .stat_hit (stat_hit),
      .ctl_val  (ctl_val),
      .status   (status),
      .rdata    (prdata)
   );

   assign pready  = 1'b1;
   assign pslverr = 1'b0;

   AST_SHUT_BLOCKS_SW: assert property (@(posedge pclk) disable iff (!presetn)
      (acc_wr && !pdbg_i && locked) |=> $stable(dbg_en_o)); // R4

   AST_IDLE_STEADY: assert property (@(posedge pclk) disable iff (!presetn)
      !acc_wr |=> $stable(dbg_en_o)); // R11

endmodule

// File: tb/test_dbgctl_top.sv
`timescale 1ns/1ps
module test_dbgctl_top;

   localparam int  N   = 5;
   localparam logic [31:0] KEY = 32'hC5AC_CE55;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [11:0] paddr = '0;
   logic [31:0] pwdata = '0;
   logic        pdbg = 1'b0;
   logic        lp = 1'b0;
   logic [31:0] prdata;
   logic        pready, pslverr;
   logic [N-1:0] dbg_en;

   int checks = 0;
   int errors = 0;

   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic [31:0] model[N];

   always #2.5 clk = ~clk;

   dbgctl_top i_dbgctl_top (
      .pclk(clk), .presetn(rst_n), .psel(psel), .penable(penable),
      .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .pdbg_i(pdbg),
      .core_lp_i(lp), .prdata(prdata), .pready(pready), .pslverr(pslverr),
      .dbg_en_o(dbg_en)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // monitor: response flags on every access, read data against scoreboard
   always @(negedge clk) begin
      if (psel && penable) begin
         chk("R10 pready/pslverr", {30'd0, pready, pslverr}, 32'h2);
         if (!pwrite) begin
            if (exp_q.size() == 0) begin
               chk("scoreboard underflow", 32'd1, 32'd0);
            end else begin
               chk(tag_q.pop_front(), prdata, exp_q.pop_front());
            end
         end
      end
   end

   task automatic apb(input logic wr, input logic [11:0] a, input logic [31:0] d, input logic dbg);
      @(posedge clk); #1;
      psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d; pdbg = dbg;
      @(posedge clk); #1;
      penable = 1'b1;
      @(posedge clk); #1;
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0; pdbg = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      apb(1'b0, a, '0, 1'b0);
   endtask

   function automatic logic [31:0] view(int i);
      if (i == 0) return (model[0] & ~32'h0020_0000) | (lp ? 32'h0020_0000 : 32'h0);
      return model[i];
   endfunction

   function automatic logic [N-1:0] en_model();
      logic [N-1:0] e;
      for (int i = 0; i < N; i++) e[i] = model[i][13];
      return e;
   endfunction

   task automatic wr_ctl(int i, logic [31:0] d, logic dbg, logic accepted);
      apb(1'b1, 12'(12'h030 + 4 * i), d, dbg);
      if (accepted) model[i] = (i == 0) ? (d & ~32'h0020_0000) : d;
   endtask

   task automatic read_all(string tag);
      for (int i = 0; i < N; i++) rd(12'(12'h030 + 4 * i), view(i), tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      chk("watchdog expired", 32'd1, 32'd0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < N; i++) model[i] = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state
      chk("R1 dbg_en after reset", 32'(dbg_en), 32'd0);
      rd(12'hFB4, 32'd3, "R1 lock status after reset");
      read_all("R1 control regs after reset");

      // R4: software writes ignored while shut
      wr_ctl(1, 32'hFFFF_FFFF, 1'b0, 1'b0);
      wr_ctl(0, 32'h0000_2000, 1'b0, 1'b0);
      chk("R4 dbg_en unchanged while locked", 32'(dbg_en), 32'd0);
      read_all("R4 regs unchanged while locked");

      // R2: key opens the lock
      apb(1'b1, 12'hFB0, KEY, 1'b0);
      rd(12'hFB4, 32'd1, "R2 lock status after key");
      rd(12'hFB0, 32'd0, "R9 lock access reads zero");

      // R6/R11: distinct patterns per register
      for (int i = 0; i < N; i++) begin
         wr_ctl(i, 32'h0000_2000 | (32'(i) << 4) | 32'hA500_0000, 1'b0, 1'b1);
         chk("R6 dbg_en after write", 32'(dbg_en), 32'(en_model()));
      end
      read_all("R11 per-register readback");
      wr_ctl(2, 32'h1234_0001, 1'b0, 1'b1);
      chk("R6 dbg_en clear of core 2", 32'(dbg_en), 32'(en_model()));
      read_all("R11 neighbours untouched");

      // R7: low-power bit on register 0
      lp = 1'b1;
      wr_ctl(0, 32'h0000_2000, 1'b0, 1'b1);
      rd(12'h030, 32'h0020_2000, "R7 lp bit reads input high");
      lp = 1'b0;
      wr_ctl(0, 32'h0020_2001, 1'b0, 1'b1);
      rd(12'h030, 32'h0000_2001, "R7 lp bit write has no effect");
      wr_ctl(3, 32'h0020_0000, 1'b0, 1'b1);
      rd(12'h03C, 32'h0020_0000, "R7 bit 21 ordinary on reg 3");

      // R3: wrong value shuts the lock
      apb(1'b1, 12'hFB0, 32'hC5AC_CE54, 1'b0);
      rd(12'hFB4, 32'd3, "R3 lock status after bad key");
      wr_ctl(4, 32'h0, 1'b0, 1'b0);
      chk("R4 dbg_en kept after relock", 32'(dbg_en), 32'(en_model()));
      read_all("R8 reads allowed while locked");

      // R5: debugger bypass
      wr_ctl(4, 32'h0, 1'b1, 1'b1);
      chk("R5 debugger write clears core 4", 32'(dbg_en), 32'(en_model()));
      wr_ctl(2, 32'h0000_2000, 1'b1, 1'b1);
      chk("R5 debugger write sets core 2", 32'(dbg_en), 32'(en_model()));
      read_all("R5 readback after debugger writes");
      rd(12'hFB4, 32'd3, "R5 bypass leaves lock shut");

      // R2 again then R3 with zero
      apb(1'b1, 12'hFB0, KEY, 1'b0);
      rd(12'hFB4, 32'd1, "R2 reopen");
      apb(1'b1, 12'hFB0, 32'h0, 1'b0);
      rd(12'hFB4, 32'd3, "R3 zero relocks");

      // R9: unmapped offsets
      rd(12'h044, 32'd0, "R9 unmapped 0x044");
      rd(12'h02C, 32'd0, "R9 unmapped 0x02C");
      rd(12'hFFC, 32'd0, "R9 unmapped 0xFFC");
      rd(12'h031, 32'd0, "R9 misaligned 0x031");

      repeat (3) @(posedge clk);
      chk("scoreboard drained", 32'(exp_q.size()), 32'd0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule